// File: doc/BRIEF.md
# Mode-Selectable Serial Shift Register

This block moves one byte at a time between a parallel register and a two-wire serial link, a shift-clock line and a serial-data line. A three-bit mode input picks the direction (receive or transmit) and the source of the shift clock. The source can be a strobe from an external timer, the system clock, or a clock supplied by the far end. When the block makes the shift clock itself, it drives the clock line. In the external-clock modes it listens on that line instead.

Software starts a byte by writing or reading the data register. The block then shifts eight bits, raises `done`, and stops with the clock line parked high. One transmit mode runs without stopping: it rotates the register out over and over and never raises `done`.

The register port is a pair of one-cycle strobes. There is no back-pressure: every strobe is accepted in the cycle it is presented, and `rd_data` always shows the shift register. The serial side has no handshake beyond its clock line.

Top module: `ssr_serial_shift`

## Requirements
- R1: After reset, `done` is 0, `sclk_out` is 1 and `rd_data` is 0. A `wr_en` strobe loads `wr_data` into the shift register, and `rd_data` shows the new value in the next cycle.
- R2: Mode codes are as follows. 000 is off. 001, 010 and 011 receive, clocked by the timer, the system clock and the external clock respectively. 100 transmits free-running on the timer. 101, 110 and 111 transmit, clocked by the timer, the system clock and the external clock respectively. `sdata_oe` is 1 exactly in the transmit modes.
- R3: When transmitting, `sdata_out` always shows bit 7 of the register, so bits leave MSB first. Each rising shift-clock edge rotates the register left by one. After a full byte the register holds its original value again.
- R4: When receiving, `sdata_in` is captured on each rising shift-clock edge into bit 0 while the register shifts left. The first bit received ends up in bit 7.
- R5: In the timer and system-clock modes, `sclk_oe` is 1 and `sclk_out` idles high. `sclk_out` toggles once per tick, so one bit takes two ticks. A tick is a `timer_tick` pulse in the timer modes and every cycle in the system-clock modes. With no `timer_tick`, a timer-mode transfer does not advance.
- R6: In the external-clock modes, `sclk_oe` is 0. `sclk_in` passes through a two-stage synchronizer, and each rising edge seen there shifts one bit.
- R7: In every mode except free-running, `done` rises after the eighth rising shift-clock edge. Shifting then stops, `sclk_out` stays high and the register holds its value.
- R8: In the free-running mode the register keeps rotating out with no gap between bytes, and `done` never rises.
- R9: A `wr_en` or `rd_en` strobe clears `done`, parks `sclk_out` high and restarts an eight-bit transfer. If a strobe lands in the same cycle as a shift tick, the strobe wins and the tick is dropped.
- R10: In mode 000 nothing shifts: `sclk_out` is 1 and both enables are 0. Entering mode 000 abandons a running transfer. Leaving mode 000 does not resume the transfer; only a new strobe starts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 3 | Direction and clock-source select |
| timer_tick | input | 1 | One-cycle rate strobe from an external timer |
| wr_en | input | 1 | Load strobe for the data register; also starts a transfer |
| rd_en | input | 1 | Read strobe for the data register; also starts a transfer |
| wr_data | input | 8 | Value loaded by `wr_en` |
| rd_data | output | 8 | Current shift register contents |
| done | output | 1 | Byte-complete flag |
| sclk_in | input | 1 | Shift clock from the far end (external-clock modes) |
| sclk_out | output | 1 | Shift clock produced by the block |
| sclk_oe | output | 1 | Drive enable for the shift-clock line |
| sdata_in | input | 1 | Serial receive data |
| sdata_out | output | 1 | Serial transmit data (register MSB) |
| sdata_oe | output | 1 | Drive enable for the serial-data line |

## Verification
Two things can fall in the same cycle: a register strobe that restarts the transfer, and a shift tick that would move a bit or finish the byte. The bench provokes this in a timer-driven receive. It lets seven bits arrive, then raises `timer_tick` together with a `wr_en` that loads a marker byte. It then expects the marker to sit unshifted in `rd_data`, `done` to stay low and the clock to be parked high. A full further byte is then needed before `done` rises, which shows that the dropped tick did not count toward the new transfer.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [2:0] {
    SSR_OFF      = 3'b000,
    SSR_IN_TMR   = 3'b001,
    SSR_IN_SYS   = 3'b010,
    SSR_IN_EXT   = 3'b011,
    SSR_OUT_FREE = 3'b100,
    SSR_OUT_TMR  = 3'b101,
    SSR_OUT_SYS  = 3'b110,
    SSR_OUT_EXT  = 3'b111
  } ssr_mode_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_TMR,
    SRC_SYS,
    SRC_EXT
  } ssr_src_e;

  // Clock source encoded in the low mode bits; 000 alone has none.
  function automatic ssr_src_e mode_src(input logic [2:0] m);
    case (m[1:0])
      2'b00:   return m[2] ? SRC_TMR : SRC_NONE;
      2'b01:   return SRC_TMR;
      2'b10:   return SRC_SYS;
      default: return SRC_EXT;
    endcase
  endfunction

  function automatic logic mode_is_tx(input logic [2:0] m);
    return m[2];
  endfunction

  function automatic logic mode_is_free(input logic [2:0] m);
    return m == SSR_OUT_FREE;
  endfunction

endpackage

// File: rtl/ssr_clk_gen.sv
module ssr_clk_gen
  import ssr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  ssr_src_e src,
  input  logic     active,
  input  logic     restart,
  input  logic     timer_tick,
  input  logic     sclk_in,
  output logic     shift_evt,
  output logic     sclk_out
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev;
  logic                   sclk_q;
  logic                   int_src;
  logic                   int_tick;
  logic                   ext_rise;

  // Synchronizer chain for the far-end clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      ext_prev <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], sclk_in};
      ext_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  assign int_src  = (src == SRC_TMR) || (src == SRC_SYS);
  assign int_tick = (src == SRC_SYS) || ((src == SRC_TMR) && timer_tick);
  assign ext_rise = sync_q[SYNC_STAGES-1] && !ext_prev;

  // A rising edge of the generated clock is a tick taken while it is low.
  assign shift_evt = active && !restart &&
                     ((int_src && int_tick && !sclk_q) ||
                      ((src == SRC_EXT) && ext_rise));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              sclk_q <= 1'b1;
    else if (restart || !active || !int_src) sclk_q <= 1'b1;
    else if (int_tick)                       sclk_q <= !sclk_q;
  end

  assign sclk_out = sclk_q;

endmodule

// File: rtl/ssr_bit_ctr.sv
module ssr_bit_ctr #(
  parameter int BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic evt,
  output logic last_evt
);

  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;

  logic [CW-1:0] cnt;

  assign last_evt = evt && (cnt == CW'(BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (evt)     cnt <= last_evt ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         evt,
  input  logic         dir_tx,
  input  logic         ser_in,
  output logic [W-1:0] q
);

  logic fill;

  // Transmit rotates; receive takes the line into the LSB.
  assign fill = dir_tx ? q[W-1] : ser_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (evt)  q <= {q[W-2:0], fill};
  end

endmodule

// File: rtl/ssr_serial_shift.sv
module ssr_serial_shift
  import ssr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             timer_tick,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             done,
  input  logic             sclk_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  input  logic             sdata_in,
  output logic             sdata_out,
  output logic             sdata_oe
);

  ssr_src_e         src;
  logic             access;
  logic             active;
  logic             shift_evt;
  logic             last_evt;
  logic             free_run;
  logic [WIDTH-1:0] sr_q;

  assign src      = mode_src(mode);
  assign access   = wr_en || rd_en;
  assign free_run = mode_is_free(mode);

  ssr_clk_gen #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src),
    .active    (active),
    .restart   (access),
    .timer_tick(timer_tick),
    .sclk_in   (sclk_in),
    .shift_evt (shift_evt),
    .sclk_out  (sclk_out)
  );

  ssr_bit_ctr #(.BITS(WIDTH)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (access),
    .evt     (shift_evt),
    .last_evt(last_evt)
  );

  ssr_shifter #(.W(WIDTH)) u_sr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wr_en),
    .load_val(wr_data),
    .evt     (shift_evt),
    .dir_tx  (mode_is_tx(mode)),
    .ser_in  (sdata_in),
    .q       (sr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         active <= 1'b0;
    else if (src == SRC_NONE)           active <= 1'b0;
    else if (access)                    active <= 1'b1;
    else if (last_evt && !free_run)     active <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         done <= 1'b0;
    else if (access)                    done <= 1'b0;
    else if (last_evt && !free_run)     done <= 1'b1;
  end

  assign rd_data   = sr_q;
  assign sdata_out = sr_q[WIDTH-1];
  assign sdata_oe  = mode_is_tx(mode);
  assign sclk_oe   = (src == SRC_TMR) || (src == SRC_SYS);

endmodule

// File: rtl/ssr_serial_shift_chk.sv
module ssr_serial_shift_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode,
  input logic             wr_en,
  input logic             rd_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] rd_data,
  input logic             done,
  input logic             sclk_out
);

  // R1: a load strobe shows up in the register next cycle
  a_r1_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  // R7: a finished byte is frozen until the next strobe
  a_r7_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_en && !rd_en) |=> $stable(rd_data));

  // R7: clock parked high while the flag is up
  a_r7_done_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sclk_out);

  // R9: strobe clears flag and parks the clock
  a_r9_access_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |=> (!done && sclk_out));

  // R10: off mode keeps the clock high
  a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000) |=> sclk_out);

  // R8: free-running never raises the flag
  a_r8_free_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b100 && !done) |=> !done);

endmodule

bind ssr_serial_shift ssr_serial_shift_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_ssr_serial_shift.sv
module tb_ssr_serial_shift;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic       timer_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       done;
  logic       sclk_in = 1'b1;
  logic       sclk_out;
  logic       sclk_oe;
  logic       sdata_in = 1'b0;
  logic       sdata_out;
  logic       sdata_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ssr_serial_shift dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .timer_tick(timer_tick),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
    .done(done), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sdata_in(sdata_in), .sdata_out(sdata_out), .sdata_oe(sdata_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit is_wr, input logic [7:0] d);
    @(negedge clk);
    wr_en = is_wr; rd_en = !is_wr; wr_data = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic tmr_pulse();
    @(negedge clk); timer_tick = 1;
    @(negedge clk); timer_tick = 0;
  endtask

  task automatic t_reset();
    check("R1 reset done", done, 0);
    check("R1 reset sclk_out", sclk_out, 1);
    check("R1 reset rd_data", rd_data, 0);
  endtask

  task automatic t_out_sys();
    logic [7:0] got = 0;
    mode = 3'b110;
    access(1, 8'hA5);
    check("R1 load", rd_data, 8'hA5);
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      if (i == 15) check("R7 not done early", done, 0);
      if (sclk_out == 0) got = {got[6:0], sdata_out};
    end
    check("R7 done after 8 bits", done, 1);
    check("R3 msb-first stream", got, 8'hA5);
    check("R3 rotated back", rd_data, 8'hA5);
    check("R2 tx data oe", sdata_oe, 1);
    check("R5 clk oe", sclk_oe, 1);
    repeat (4) @(negedge clk);
    check("R7 clock parked", sclk_out, 1);
  endtask

  task automatic t_rd_restart();
    access(0, 8'h00);
    check("R9 read clears done", done, 0);
    @(negedge clk);
    check("R9 read restarts clock", sclk_out, 0);
    repeat (15) @(negedge clk);
    check("R9 restarted byte completes", done, 1);
  endtask

  task automatic t_in_sys();
    logic [7:0] pat = 8'h3C;
    int idx = 7;
    mode = 3'b010;
    access(1, 8'h00);
    check("R2 rx data oe", sdata_oe, 0);
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      if (sclk_out == 0 && idx >= 0) begin
        sdata_in = pat[idx];
        idx--;
      end
    end
    check("R7 rx done", done, 1);
    check("R4 rx byte", rd_data, 8'h3C);
  endtask

  task automatic t_out_tmr();
    logic [7:0] got = 0;
    mode = 3'b101;
    access(1, 8'h96);
    repeat (10) @(negedge clk);
    check("R5 no tick no clock", sclk_out, 1);
    check("R5 no tick no shift", rd_data, 8'h96);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (k == 15) check("R7 timer not done early", done, 0);
      if (sclk_out == 0) got = {got[6:0], sdata_out};
      timer_tick = 1;
      @(negedge clk);
      timer_tick = 0;
    end
    check("R5 timer stream", got, 8'h96);
    check("R7 timer done", done, 1);
  endtask

  task automatic t_in_ext();
    logic [7:0] pat = 8'hE1;
    mode = 3'b011;
    access(0, 8'h00);
    check("R6 ext clk oe off", sclk_oe, 0);
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk);
      sdata_in = pat[b];
      sclk_in = 0;
      repeat (4) @(negedge clk);
      sclk_in = 1;
      repeat (4) @(negedge clk);
      if (b == 1) check("R7 ext rx not done at 7", done, 0);
    end
    check("R6 ext rx done", done, 1);
    check("R6 ext rx byte", rd_data, 8'hE1);
  endtask

  task automatic t_out_ext();
    logic [7:0] got = 0;
    mode = 3'b111;
    access(1, 8'h4D);
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk);
      sclk_in = 0;
      repeat (3) @(negedge clk);
      got = {got[6:0], sdata_out};
      sclk_in = 1;
      repeat (4) @(negedge clk);
    end
    check("R6 ext tx stream", got, 8'h4D);
    check("R6 ext tx done", done, 1);
    check("R2 ext tx oe", sdata_oe, 1);
  endtask

  task automatic t_free();
    logic [31:0] got = 0;
    int seen_done = 0;
    int lows = 0;
    mode = 3'b100;
    access(1, 8'h81);
    timer_tick = 1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (done) seen_done++;
      if (sclk_out == 0) begin
        got = {got[30:0], sdata_out};
        lows++;
      end
    end
    timer_tick = 0;
    check("R8 free never done", seen_done, 0);
    check("R8 free bit count", lows, 20);
    check("R8 free repeats", got[19:4], 16'h8181);
  endtask

  task automatic t_off();
    mode = 3'b110;
    access(1, 8'hF0);
    repeat (2) @(negedge clk);
    mode = 3'b000;
    @(negedge clk);
    check("R10 abandoned value", rd_data, 8'hE1);
    check("R10 off clock high", sclk_out, 1);
    check("R10 off clk oe", sclk_oe, 0);
    check("R10 off data oe", sdata_oe, 0);
    timer_tick = 1;
    repeat (8) @(negedge clk);
    timer_tick = 0;
    check("R10 off no shift", rd_data, 8'hE1);
    access(1, 8'h5A);
    repeat (6) @(negedge clk);
    check("R10 off write loads", rd_data, 8'h5A);
    check("R10 off write no done", done, 0);
    mode = 3'b110;
    repeat (6) @(negedge clk);
    check("R10 no resume value", rd_data, 8'h5A);
    check("R10 no resume clock", sclk_out, 1);
  endtask

  task automatic t_collide();
    logic [7:0] pat = 8'hC3;
    int idx = 7;
    mode = 3'b001;
    access(0, 8'h00);
    sdata_in = 1;
    repeat (15) tmr_pulse();
    check("R9 pre-collision clock low", sclk_out, 0);
    @(negedge clk);
    timer_tick = 1; wr_en = 1; wr_data = 8'h42;
    @(negedge clk);
    timer_tick = 0; wr_en = 0;
    check("R9 strobe beats tick value", rd_data, 8'h42);
    check("R9 strobe beats tick done", done, 0);
    check("R9 strobe parks clock", sclk_out, 1);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (k == 15) check("R9 full byte needed", done, 0);
      if (sclk_out == 0 && idx >= 0) begin
        sdata_in = pat[idx];
        idx--;
      end
      timer_tick = 1;
      @(negedge clk);
      timer_tick = 0;
    end
    check("R4 timer rx byte", rd_data, 8'hC3);
    check("R7 timer rx done", done, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_out_sys();
    t_rd_restart();
    t_in_sys();
    t_out_tmr();
    t_in_ext();
    t_out_ext();
    t_free();
    t_off();
    t_collide();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

endmodule